// File: doc/BRIEF.md
# Time-Triggered Frame Assembler With Header and Frame CRCs

This block turns a set of host-supplied frame fields and a stream of 16-bit payload words into one serial byte stream for a time-triggered bus frame. A frame starts with a 40-bit header and ends with a 24-bit check trailer. Between them sit 0 to 127 payload words, each sent as two bytes, so a payload holds at most 254 bytes. The header contains a short check code over a subset of its fields. The trailer is a longer check code over every header and payload byte.

The host pulses `go` while the block is idle. The fields present on the same edge are captured and the frame then streams out with no further host action, apart from supplying payload words on a valid/ready handshake. A request that sets the startup indicator without the sync indicator is refused. In that case an error strobe is raised and nothing is sent.

Top module: `tt_frame_asm`

## Requirements
- R1: Header bits, first sent to last: reserved, preamble flag, null flag (0 = payload carries no valid data, 1 = valid data), sync flag, startup flag, frame ID (11 bits), payload length in words (7 bits), header check (11 bits), cycle count (6 bits). Each field is sent MSB first, and the header goes out as 5 bytes, MSB of each byte first.
- R2: The header check is an 11-bit CRC with polynomial 0x385 and start value 0x01A. It is fed MSB first over 20 bits in this order: sync flag, startup flag, frame ID, payload length.
- R3: The trailer is a 24-bit CRC with polynomial 0x5D6DCB and start value 0xFEDCBA. It is fed MSB first over every header byte and then every payload byte. It is sent as 3 bytes, most significant byte first.
- R4: A frame holds exactly 8 + 2·length bytes. Each payload word is sent high byte first, and words keep their arrival order.
- R5: `ob_sof` is high only on the first header byte. `ob_last` is high only on the final trailer byte. `ob_valid` is low in the cycle after `ob_last`.
- R6: `pl_ready` is low in every cycle that carries a header or trailer byte.
- R7: With a payload length of 0, the first trailer byte directly follows the fifth header byte.
- R8: A `go` with startup=1 and sync=0 raises `cfg_err` for one cycle in the next cycle, starts no frame and leaves the block idle.
- R9: A `go` received while a frame is in progress is ignored. The running frame is unchanged and no second frame follows.
- R10: When payload words arrive late, `ob_valid` drops for the waiting cycles. No byte is lost or duplicated, and a word is taken only on a cycle where `pl_valid` and `pl_ready` are both high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| go | input | 1 | Start request, taken only when idle |
| f_rsv | input | 1 | Reserved header bit |
| f_pre | input | 1 | Payload preamble flag |
| f_null | input | 1 | Null flag (0 = no valid data) |
| f_sync | input | 1 | Sync flag |
| f_stup | input | 1 | Startup flag |
| f_id | input | 11 | Frame ID |
| f_len | input | 7 | Payload length in 16-bit words |
| f_cyc | input | 6 | Cycle count |
| pl_word | input | 16 | Payload word |
| pl_valid | input | 1 | Payload word offered |
| pl_ready | output | 1 | Payload word taken this cycle if valid |
| ob_data | output | 8 | Output byte |
| ob_valid | output | 1 | Output byte present |
| ob_sof | output | 1 | First byte of frame |
| ob_last | output | 1 | Final byte of frame |
| frm_idle | output | 1 | Block idle, ready for `go` |
| cfg_err | output | 1 | Refused request strobe |

## Verification
Two things can land in the same clock. In the cycle that sends the low byte of a word, the block can also accept the next word. In that same cycle, the trailer CRC absorbs the byte being sent. The bench provokes this overlap with runs that always offer a word and with runs that offer words at random gaps. Each frame is then judged byte for byte, including its trailer, against CRCs that the bench computes itself. A second overlap comes from a `go` pulsed during the header of a running frame. That frame must come out intact, and the output must stay silent afterwards.

// File: rtl/tt_frame_pkg.sv
package tt_frame_pkg;
    localparam int unsigned ID_W_DEF    = 11;
    localparam int unsigned LEN_W_DEF   = 7;
    localparam int unsigned CYC_W_DEF   = 6;
    localparam int unsigned HCRC_W_DEF  = 11;
    localparam int unsigned FCRC_W_DEF  = 24;
    localparam int unsigned WORD_W_DEF  = 16;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_HDR,
        ST_PGET,
        ST_PHI,
        ST_PLO,
        ST_TRL
    } asm_state_e;
endpackage

// File: rtl/tt_crc_serial.sv
module tt_crc_serial #(
    parameter int unsigned       CW   = 11,
    parameter int unsigned       DW   = 8,
    parameter logic [CW-1:0]     POLY = '0
) (
    input  logic [CW-1:0] crc_in,
    input  logic [DW-1:0] data,
    output logic [CW-1:0] crc_out
);
    logic [CW-1:0] acc;
    logic          fb;

    always_comb begin
        acc = crc_in;
        fb  = 1'b0;
        for (int i = DW - 1; i >= 0; i--) begin
            fb  = acc[CW-1] ^ data[i];
            acc = {acc[CW-2:0], 1'b0};
            if (fb) begin
                acc = acc ^ POLY;
            end
        end
        crc_out = acc;
    end
endmodule

// File: rtl/tt_hdr_pack.sv
module tt_hdr_pack
    import tt_frame_pkg::*;
#(
    parameter int unsigned         ID_W      = ID_W_DEF,
    parameter int unsigned         LEN_W     = LEN_W_DEF,
    parameter int unsigned         CYC_W     = CYC_W_DEF,
    parameter int unsigned         HCRC_W    = HCRC_W_DEF,
    parameter logic [HCRC_W-1:0]   HCRC_POLY = 11'h385,
    parameter logic [HCRC_W-1:0]   HCRC_INIT = 11'h01A,
    localparam int unsigned        COV_W     = 2 + ID_W + LEN_W,
    localparam int unsigned        HDR_W     = 5 + ID_W + LEN_W + HCRC_W + CYC_W
) (
    input  logic             rsv,
    input  logic             pre,
    input  logic             nul,
    input  logic             syn,
    input  logic             stup,
    input  logic [ID_W-1:0]  fid,
    input  logic [LEN_W-1:0] len,
    input  logic [CYC_W-1:0] cyc,
    output logic [HDR_W-1:0] hdr
);
    logic [COV_W-1:0]  cov;
    logic [HCRC_W-1:0] hcrc;

    assign cov = {syn, stup, fid, len};

    tt_crc_serial #(
        .CW   (HCRC_W),
        .DW   (COV_W),
        .POLY (HCRC_POLY)
    ) hcrc_i (
        .crc_in  (HCRC_INIT),
        .data    (cov),
        .crc_out (hcrc)
    );

    assign hdr = {rsv, pre, nul, syn, stup, fid, len, hcrc, cyc};
endmodule

// File: rtl/tt_frame_asm.sv
module tt_frame_asm
    import tt_frame_pkg::*;
#(
    parameter int unsigned         ID_W      = ID_W_DEF,
    parameter int unsigned         LEN_W     = LEN_W_DEF,
    parameter int unsigned         CYC_W     = CYC_W_DEF,
    parameter int unsigned         HCRC_W    = HCRC_W_DEF,
    parameter int unsigned         FCRC_W    = FCRC_W_DEF,
    parameter int unsigned         WORD_W    = WORD_W_DEF,
    parameter logic [HCRC_W-1:0]   HCRC_POLY = 11'h385,
    parameter logic [HCRC_W-1:0]   HCRC_INIT = 11'h01A,
    parameter logic [FCRC_W-1:0]   FCRC_POLY = 24'h5D6DCB,
    parameter logic [FCRC_W-1:0]   FCRC_INIT = 24'hFEDCBA
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              go,
    input  logic              f_rsv,
    input  logic              f_pre,
    input  logic              f_null,
    input  logic              f_sync,
    input  logic              f_stup,
    input  logic [ID_W-1:0]   f_id,
    input  logic [LEN_W-1:0]  f_len,
    input  logic [CYC_W-1:0]  f_cyc,
    input  logic [WORD_W-1:0] pl_word,
    input  logic              pl_valid,
    output logic              pl_ready,
    output logic [7:0]        ob_data,
    output logic              ob_valid,
    output logic              ob_sof,
    output logic              ob_last,
    output logic              frm_idle,
    output logic              cfg_err
);
    localparam int unsigned HDR_W     = 5 + ID_W + LEN_W + HCRC_W + CYC_W;
    localparam int unsigned HDR_BYTES = HDR_W / 8;
    localparam int unsigned TRL_BYTES = FCRC_W / 8;
    localparam int unsigned IDX_W     = 3;

    typedef struct packed {
        asm_state_e         st;
        logic [IDX_W-1:0]   idx;
        logic [HDR_W-1:0]   hdr;
        logic [FCRC_W-1:0]  fcrc;
        logic [LEN_W-1:0]   left;
        logic [WORD_W-1:0]  word;
        logic               err;
    } asm_regs_t;

    asm_regs_t r_d, r_q;

    logic [HDR_W-1:0]  hdr_new;
    logic [HDR_W-1:0]  hdr_sh;
    logic [FCRC_W-1:0] fcrc_sh;
    logic [FCRC_W-1:0] fcrc_upd;

    tt_hdr_pack #(
        .ID_W      (ID_W),
        .LEN_W     (LEN_W),
        .CYC_W     (CYC_W),
        .HCRC_W    (HCRC_W),
        .HCRC_POLY (HCRC_POLY),
        .HCRC_INIT (HCRC_INIT)
    ) pack_i (
        .rsv  (f_rsv),
        .pre  (f_pre),
        .nul  (f_null),
        .syn  (f_sync),
        .stup (f_stup),
        .fid  (f_id),
        .len  (f_len),
        .cyc  (f_cyc),
        .hdr  (hdr_new)
    );

    tt_crc_serial #(
        .CW   (FCRC_W),
        .DW   (8),
        .POLY (FCRC_POLY)
    ) fcrc_i (
        .crc_in  (r_q.fcrc),
        .data    (ob_data),
        .crc_out (fcrc_upd)
    );

    assign hdr_sh  = r_q.hdr  << {r_q.idx, 3'b000};
    assign fcrc_sh = r_q.fcrc << {r_q.idx, 3'b000};

    always_comb begin
        r_d      = r_q;
        r_d.err  = 1'b0;
        pl_ready = 1'b0;
        ob_data  = 8'h00;
        ob_valid = 1'b0;
        ob_sof   = 1'b0;
        ob_last  = 1'b0;
        unique case (r_q.st)
            ST_IDLE: begin
                if (go) begin
                    if (f_stup && !f_sync) begin
                        r_d.err = 1'b1;
                    end else begin
                        r_d.st   = ST_HDR;
                        r_d.idx  = '0;
                        r_d.hdr  = hdr_new;
                        r_d.fcrc = FCRC_INIT;
                        r_d.left = f_len;
                    end
                end
            end
            ST_HDR: begin
                ob_valid = 1'b1;
                ob_data  = hdr_sh[HDR_W-1 -: 8];
                ob_sof   = (r_q.idx == '0);
                r_d.fcrc = fcrc_upd;
                if (r_q.idx == IDX_W'(HDR_BYTES - 1)) begin
                    r_d.idx = '0;
                    r_d.st  = (r_q.left == '0) ? ST_TRL : ST_PGET;
                end else begin
                    r_d.idx = r_q.idx + IDX_W'(1);
                end
            end
            ST_PGET: begin
                pl_ready = 1'b1;
                if (pl_valid) begin
                    r_d.word = pl_word;
                    r_d.st   = ST_PHI;
                end
            end
            ST_PHI: begin
                ob_valid = 1'b1;
                ob_data  = r_q.word[WORD_W-1 -: 8];
                r_d.fcrc = fcrc_upd;
                r_d.st   = ST_PLO;
            end
            ST_PLO: begin
                ob_valid = 1'b1;
                ob_data  = r_q.word[7:0];
                r_d.fcrc = fcrc_upd;
                r_d.left = r_q.left - LEN_W'(1);
                if (r_q.left > LEN_W'(1)) begin
                    pl_ready = 1'b1;
                    if (pl_valid) begin
                        r_d.word = pl_word;
                        r_d.st   = ST_PHI;
                    end else begin
                        r_d.st   = ST_PGET;
                    end
                end else begin
                    r_d.idx = '0;
                    r_d.st  = ST_TRL;
                end
            end
            ST_TRL: begin
                ob_valid = 1'b1;
                ob_data  = fcrc_sh[FCRC_W-1 -: 8];
                if (r_q.idx == IDX_W'(TRL_BYTES - 1)) begin
                    ob_last = 1'b1;
                    r_d.idx = '0;
                    r_d.st  = ST_IDLE;
                end else begin
                    r_d.idx = r_q.idx + IDX_W'(1);
                end
            end
            default: r_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q      <= '0;
            r_q.st   <= ST_IDLE;
        end else begin
            r_q      <= r_d;
        end
    end

    assign frm_idle = (r_q.st == ST_IDLE);
    assign cfg_err  = r_q.err;

    // R6
    sof_noready_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ob_sof |-> !pl_ready);

    // R5
    last_then_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ob_last |=> !ob_valid);

    // R5
    sof_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ob_sof |=> !ob_sof);

    // R8
    err_no_frame_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_err |-> (frm_idle && !ob_valid));

    // R10
    take_then_emit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pl_valid && pl_ready) |=> (ob_valid && !ob_last && !ob_sof));
endmodule

// File: tb/tt_frame_asm_tb.sv
module tt_frame_asm_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        go = 1'b0;
    logic        f_rsv = 1'b0, f_pre = 1'b0, f_null = 1'b0, f_sync = 1'b0, f_stup = 1'b0;
    logic [10:0] f_id = '0;
    logic [6:0]  f_len = '0;
    logic [5:0]  f_cyc = '0;
    logic [15:0] pl_word = '0;
    logic        pl_valid = 1'b0;
    logic        pl_ready;
    logic [7:0]  ob_data;
    logic        ob_valid, ob_sof, ob_last, frm_idle, cfg_err;

    int n_chk = 0;
    int n_fail = 0;
    int seed_dummy;

    logic [7:0]  exp_b [0:263];
    logic [7:0]  got_b [0:263];
    logic [15:0] wds   [0:127];

    always #2.5 clk = ~clk;

    tt_frame_asm dut_i (
        .clk(clk), .rst_n(rst_n), .go(go),
        .f_rsv(f_rsv), .f_pre(f_pre), .f_null(f_null), .f_sync(f_sync), .f_stup(f_stup),
        .f_id(f_id), .f_len(f_len), .f_cyc(f_cyc),
        .pl_word(pl_word), .pl_valid(pl_valid), .pl_ready(pl_ready),
        .ob_data(ob_data), .ob_valid(ob_valid), .ob_sof(ob_sof), .ob_last(ob_last),
        .frm_idle(frm_idle), .cfg_err(cfg_err)
    );

    task automatic chk(input bit ok, input string req, input longint act, input longint expv);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, expv);
        end
    endtask

    function automatic logic [10:0] hcrc_f(input logic [19:0] d);
        logic [10:0] c = 11'h01A;
        for (int i = 19; i >= 0; i--) begin
            logic fb = c[10] ^ d[i];
            c = {c[9:0], 1'b0};
            if (fb) c = c ^ 11'h385;
        end
        return c;
    endfunction

    function automatic logic [23:0] fcrc_f(input int nbytes);
        logic [23:0] c = 24'hFEDCBA;
        for (int k = 0; k < nbytes; k++) begin
            for (int i = 7; i >= 0; i--) begin
                logic fb = c[23] ^ exp_b[k][i];
                c = {c[22:0], 1'b0};
                if (fb) c = c ^ 24'h5D6DCB;
            end
        end
        return c;
    endfunction

    task automatic run_frame(input logic [4:0] ind, input logic [10:0] fid, input logic [6:0] len,
                             input logic [5:0] cyc, input int gap, input bit poke);
        logic [10:0] hc;
        logic [39:0] hdr;
        logic [23:0] tc;
        int total, n, widx, guard, lastpos, sofbad, rdybad, bytebad, quietbad;
        bit done, vld;
        hc  = hcrc_f({ind[1], ind[0], fid, len});
        hdr = {ind, fid, len, hc, cyc};
        total = 8 + 2 * int'(len);
        for (int i = 0; i < 5; i++) exp_b[i] = hdr[39 - 8*i -: 8];
        for (int w = 0; w < int'(len); w++) begin
            wds[w] = 16'($urandom);
            exp_b[5 + 2*w]     = wds[w][15:8];
            exp_b[5 + 2*w + 1] = wds[w][7:0];
        end
        tc = fcrc_f(5 + 2 * int'(len));
        for (int i = 0; i < 3; i++) exp_b[5 + 2*int'(len) + i] = tc[23 - 8*i -: 8];

        {f_rsv, f_pre, f_null, f_sync, f_stup} = ind;
        f_id = fid; f_len = len; f_cyc = cyc;
        go = 1'b1;
        @(negedge clk);
        go = 1'b0;
        n = 0; widx = 0; guard = 0; done = 0; lastpos = -1;
        sofbad = 0; rdybad = 0; bytebad = 0;
        while (!done && guard < 3000) begin
            if (ob_valid) begin
                if (n < 264) got_b[n] = ob_data;
                if (ob_sof != (n == 0)) sofbad++;
                if (pl_ready && (n < 5 || n >= 5 + 2*int'(len))) rdybad++;
                if (ob_last) begin done = 1; lastpos = n; end
                n++;
            end
            go = (poke && n == 3) ? 1'b1 : 1'b0;
            vld = (widx < int'(len)) && (($urandom % 100) >= gap);
            pl_valid = vld;
            pl_word  = (widx < int'(len)) ? wds[widx] : 16'hDEAD;
            if (vld && pl_ready) widx++;
            guard++;
            if (!done) @(negedge clk);
        end
        go = 1'b0;
        pl_valid = 1'b0;
        // R4 / R7: frame length
        chk(n == total, (len == 0) ? "R7 byte count" : "R4 byte count", n, total);
        // R5: last position
        chk(lastpos == total - 1, "R5 last position", lastpos, total - 1);
        chk(sofbad == 0, "R5 sof placement", sofbad, 0);
        // R6
        chk(rdybad == 0, "R6 ready during header/trailer", rdybad, 0);
        for (int i = 0; i < 5 && i < n; i++) if (got_b[i] !== exp_b[i]) bytebad++;
        chk(bytebad == 0, "R1 header bytes", bytebad, 0);
        if (n >= 4)
            chk({got_b[2][6:0], got_b[3], got_b[4][7:6]} >> 6 == {5'b0, hc} >> 0 ? 1'b1 :
                ({got_b[2][0], got_b[3], got_b[4][7:6]} == hc),
                "R2 header CRC field", {got_b[2][0], got_b[3], got_b[4][7:6]}, hc);
        bytebad = 0;
        for (int i = 5; i < 5 + 2*int'(len) && i < n; i++) if (got_b[i] !== exp_b[i]) bytebad++;
        chk(bytebad == 0, gap > 0 ? "R10 payload bytes with gaps" : "R4 payload bytes", bytebad, 0);
        bytebad = 0;
        for (int i = 5 + 2*int'(len); i < total && i < n; i++) if (got_b[i] !== exp_b[i]) bytebad++;
        chk(bytebad == 0, "R3 trailer bytes", bytebad, 0);
        quietbad = 0;
        for (int i = 0; i < 4; i++) begin
            @(negedge clk);
            if (ob_valid || !frm_idle) quietbad++;
        end
        chk(quietbad == 0, poke ? "R9 no second frame after busy go" : "R5 quiet after last", quietbad, 0);
    endtask

    task automatic run_bad(input logic [10:0] fid, input logic [6:0] len);
        {f_rsv, f_pre, f_null, f_sync, f_stup} = 5'b00101;
        f_id = fid; f_len = len; f_cyc = 6'h11;
        go = 1'b1;
        @(negedge clk);
        go = 1'b0;
        chk(cfg_err == 1'b1, "R8 error strobe", cfg_err, 1);
        chk(frm_idle && !ob_valid, "R8 no frame", {frm_idle, ob_valid}, 2'b10);
        @(negedge clk);
        chk(cfg_err == 1'b0 && !ob_valid && frm_idle, "R8 strobe one cycle", {cfg_err, ob_valid, frm_idle}, 3'b001);
    endtask

    initial begin
        seed_dummy = $urandom(32'h5EED_1234);
        repeat (3) @(negedge clk);
        chk(!ob_valid && !pl_ready && !cfg_err, "R5 reset outputs", {ob_valid, pl_ready, cfg_err}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(frm_idle && !ob_valid && !pl_ready, "R6 idle after reset", {frm_idle, ob_valid, pl_ready}, 3'b100);
        run_frame(5'b00011, 11'h001, 7'd0,   6'h00, 0,  0);
        run_frame(5'b11111, 11'h7FF, 7'd1,   6'h3F, 0,  0);
        run_frame(5'b00110, 11'h2A5, 7'd127, 6'h15, 0,  0);
        run_frame(5'b01010, 11'h123, 7'd4,   6'h07, 60, 0);
        run_frame(5'b00010, 11'h055, 7'd3,   6'h09, 0,  1);
        run_bad(11'h100, 7'd5);
        for (int t = 0; t < 24; t++) begin
            logic [4:0] ind = 5'($urandom);
            if (ind[0]) ind[1] = 1'b1;
            run_frame(ind, 11'($urandom), 7'($urandom % 128), 6'($urandom),
                      int'($urandom % 4) * 25, ($urandom % 5) == 0);
        end
        run_bad(11'($urandom), 7'd0);
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule